// File: doc/BRIEF.md
# Network Controller Register Bank

This block holds the sixteen-bit control and status registers of a network controller and exposes them to a host through a single word-addressed port. Every register follows its own write rule instead of plain storage. Some keep only certain bits of a written word. Some accept writes only while the controller's command word has its reset bit set. Some return fixed values and ignore writes. Some keep the bitwise complement of what is written, so that tally counters read back counted down. The interrupt status register is write-one-to-clear.

The receive and transmit engines that use these registers are not part of the block. They appear only as a vector of set pulses into the interrupt status register. The block drives an interrupt line from the status and mask registers. It also produces two one-cycle pulses for neighbouring logic: one requests a fetch from the receive ring when the host clears a set buffer-exhaustion status bit, and one restarts the watchdog when the host writes either watchdog timer word. Reads take one clock and are qualified by a valid strobe.

Top module: `ctrl_regbank`

## Requirements
- R1: After reset, the command register (0x00) reads 0x00A4: reset bit 7, stop bit 5 and receive-disable bit 2 are set. Receive control (0x02) reads 0x0020, with carrier sense at bit 5. End-of-buffer count (0x07) reads 0x02F8. Transmit control (0x03), interrupt mask (0x04), interrupt status (0x05), sequence count (0x08) and CAM enable (0x09) read 0x0000.
- R2: Addresses 0x10 to 0x12 (capability words), 0x13 (revision) and 0x14 (maintenance) return fixed parameter values. Writes to them have no effect.
- R3: Data configuration (0x01) stores the written value ANDed with 0xBFFF, and second configuration (0x06) stores it ANDed with 0xF017. Both accept a write only while bit 7 of the command register is 1. Otherwise the write is dropped.
- R4: Transmit control stores writes ANDed with 0xF000, receive control with 0xFFE0, and interrupt mask with 0x7FFF.
- R5: A write to interrupt status (0x05) clears each bit that is 1 in both the written word and the register. A 1 written to a bit that is already 0 leaves it 0, and 0 bits in the written word change nothing.
- R6: A status write that clears buffer-exhaustion bit 5 while that bit is set raises `ring_fetch` for exactly one cycle, in the cycle after the write. A write of bit 5 while it is already 0 raises no pulse.
- R7: The three tally registers (0x0C CRC errors, 0x0D alignment errors, 0x0E missed packets) store the bitwise inverse of the written word.
- R8: A write to either watchdog timer word (0x0A or 0x0B) raises `wdog_restart` for one cycle after the write. A write to any other address does not.
- R9: `irq` is the OR of all bits of the interrupt status ANDed with the interrupt mask. It follows a mask or status change in the same cycle that the register changes.
- R10: Each 1 on `stat_set` sets that status bit at the next edge. A same-cycle host clear of the same bit loses, and the bit stays 1.
- R11: A read with `rd_en` returns the addressed word on `rdata`, with `rd_valid` high, one cycle later. All other addresses are plain 16-bit storage that resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | AW | Word address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| stat_set | input | 16 | Engine set pulses for interrupt status bits |
| irq | output | 1 | Interrupt request |
| ring_fetch | output | 1 | One-cycle receive-ring fetch request |
| wdog_restart | output | 1 | One-cycle watchdog restart pulse |

## Verification
The assertions assume that the host raises at most one of `wr_en` and `rd_en` in a cycle. They also assume that `stat_set` carries pulses rather than static levels, so that a set bit can be observed and cleared. The stimulus drives one access at a time on the falling edge and holds `stat_set` high for a single cycle each time it is used. The status priority property relies on engine sets and host clears meeting only as the bench arranges them: one deliberate same-cycle collision on a single bit.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int DW = 16;

  typedef enum logic [2:0] {K_PLAIN, K_GATED, K_INVERT, K_STATUS, K_RDONLY} kind_e;

  localparam int ADR_CMD   = 0;
  localparam int ADR_DCFG  = 1;
  localparam int ADR_RXC   = 2;
  localparam int ADR_TXC   = 3;
  localparam int ADR_IMASK = 4;
  localparam int ADR_ISTAT = 5;
  localparam int ADR_DCFG2 = 6;
  localparam int ADR_EOBC  = 7;
  localparam int ADR_WDT_LO = 10;
  localparam int ADR_WDT_HI = 11;
  localparam int ADR_TAL_CRC  = 12;
  localparam int ADR_TAL_ALN  = 13;
  localparam int ADR_TAL_MISS = 14;
  localparam int ADR_CAP0  = 16;
  localparam int ADR_CAP1  = 17;
  localparam int ADR_CAP2  = 18;
  localparam int ADR_REV   = 19;
  localparam int ADR_MAINT = 20;

  localparam int CMD_RST_BIT = 7;
  localparam int EXH_BIT     = 5;

  function automatic kind_e reg_kind(input int a);
    case (a)
      ADR_DCFG, ADR_DCFG2:                    return K_GATED;
      ADR_TAL_CRC, ADR_TAL_ALN, ADR_TAL_MISS: return K_INVERT;
      ADR_ISTAT:                              return K_STATUS;
      ADR_CAP0, ADR_CAP1, ADR_CAP2,
      ADR_REV, ADR_MAINT:                     return K_RDONLY;
      default:                                return K_PLAIN;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_wmask(input int a);
    case (a)
      ADR_DCFG:  return 16'hBFFF;
      ADR_DCFG2: return 16'hF017;
      ADR_TXC:   return 16'hF000;
      ADR_RXC:   return 16'hFFE0;
      ADR_IMASK: return 16'h7FFF;
      default:   return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_rstval(input int a);
    case (a)
      ADR_CMD:  return 16'h00A4;
      ADR_RXC:  return 16'h0020;
      ADR_EOBC: return 16'h02F8;
      default:  return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/crb_cell.sv
module crb_cell
  import crb_pkg::*;
#(
  parameter kind_e          KIND    = K_PLAIN,
  parameter logic [DW-1:0]  RST_VAL = '0,
  parameter logic [DW-1:0]  WMASK   = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          gate_ok,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam bit NEEDS_GATE = (KIND == K_GATED);
  localparam bit INVERTS    = (KIND == K_INVERT);

  logic          accept;
  logic [DW-1:0] stored;

  assign accept = we && (!NEEDS_GATE || gate_ok);
  assign stored = (INVERTS ? ~wdata : wdata) & WMASK;

  always_ff @(posedge clk) begin
    if (rst)         q <= RST_VAL;
    else if (accept) q <= stored;
  end

  // masked-off bits never move away from their reset value
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ((q & ~WMASK) == (RST_VAL & ~WMASK)));
endmodule

// File: rtl/crb_status.sv
module crb_status
  import crb_pkg::*;
#(
  parameter int SET_BIT_EXH = EXH_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] set_in,
  input  logic [DW-1:0] imask,
  output logic [DW-1:0] istat,
  output logic          irq,
  output logic          ring_fetch
);
  logic [DW-1:0] clr_bits;

  assign clr_bits = clr_we ? (wdata & istat) : '0;
  assign irq      = |(istat & imask);

  always_ff @(posedge clk) begin
    if (rst) begin
      istat      <= '0;
      ring_fetch <= 1'b0;
    end else begin
      istat      <= (istat & ~clr_bits) | set_in;
      ring_fetch <= clr_bits[SET_BIT_EXH];
    end
  end

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (set_in != '0) |=> ((istat & $past(set_in)) == $past(set_in)));
  p_fetch_needs_set_r6: assert property (@(posedge clk) disable iff (rst)
    ring_fetch |-> $past(istat[SET_BIT_EXH]) && $past(clr_we));
  p_no_irq_unmasked_r9: assert property (@(posedge clk) disable iff (rst)
    (imask == '0) |-> !irq);
  p_w1c_no_raise_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_we && set_in == '0) |=> ((istat & ~$past(istat)) == '0));
endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank
  import crb_pkg::*;
#(
  parameter int            AW        = 6,
  parameter logic [DW-1:0] CAP0_VAL  = 16'h1A2B,
  parameter logic [DW-1:0] CAP1_VAL  = 16'h3C4D,
  parameter logic [DW-1:0] CAP2_VAL  = 16'h5E6F,
  parameter logic [DW-1:0] REV_VAL   = 16'h0006,
  parameter logic [DW-1:0] MAINT_VAL = 16'h0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_valid,
  input  logic [DW-1:0] stat_set,
  output logic          irq,
  output logic          ring_fetch,
  output logic          wdog_restart
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] q_arr [NREG];
  logic [DW-1:0] istat;
  logic          in_reset_mode;
  logic          stat_we;

  assign in_reset_mode = q_arr[ADR_CMD][CMD_RST_BIT];
  assign stat_we       = wr_en && (addr == AW'(ADR_ISTAT));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam kind_e KD = reg_kind(i);
    if (KD == K_RDONLY) begin : g_ro
      localparam logic [DW-1:0] RV = (i == ADR_CAP0) ? CAP0_VAL :
                                     (i == ADR_CAP1) ? CAP1_VAL :
                                     (i == ADR_CAP2) ? CAP2_VAL :
                                     (i == ADR_REV)  ? REV_VAL  : MAINT_VAL;
      assign q_arr[i] = RV;
    end else if (KD == K_STATUS) begin : g_st
      assign q_arr[i] = istat;
    end else begin : g_rw
      crb_cell #(
        .KIND    (KD),
        .RST_VAL (reg_rstval(i)),
        .WMASK   (reg_wmask(i))
      ) cell_i (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en && (addr == AW'(i))),
        .gate_ok (in_reset_mode),
        .wdata   (wdata),
        .q       (q_arr[i])
      );
    end
  end

  crb_status #(.SET_BIT_EXH(EXH_BIT)) status_i (
    .clk        (clk),
    .rst        (rst),
    .clr_we     (stat_we),
    .wdata      (wdata),
    .set_in     (stat_set),
    .imask      (q_arr[ADR_IMASK]),
    .istat      (istat),
    .irq        (irq),
    .ring_fetch (ring_fetch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata        <= '0;
      rd_valid     <= 1'b0;
      wdog_restart <= 1'b0;
    end else begin
      rd_valid     <= rd_en;
      if (rd_en) rdata <= q_arr[addr];
      wdog_restart <= wr_en && ((addr == AW'(ADR_WDT_LO)) || (addr == AW'(ADR_WDT_HI)));
    end
  end

  p_rd_latency_r11: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
  p_wdog_from_write_r8: assert property (@(posedge clk) disable iff (rst)
    wdog_restart |-> $past(wr_en));
  p_cfg_locked_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(ADR_DCFG) && !in_reset_mode) |=> $stable(q_arr[ADR_DCFG]));
  p_cfg2_locked_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(ADR_DCFG2) && !in_reset_mode) |=> $stable(q_arr[ADR_DCFG2]));
endmodule

// File: tb/ctrl_regbank_tb_top.sv
module ctrl_regbank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int WDOG_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          rd_valid;
  logic [15:0]   stat_set = '0;
  logic          irq;
  logic          ring_fetch;
  logic          wdog_restart;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_regbank #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .stat_set(stat_set),
    .irq(irq), .ring_fetch(ring_fetch), .wdog_restart(wdog_restart)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data is presented
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R11 actual=%h expected=<none>", rdata);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [15:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'h0000);
    rd(0, 16'h00A4, "R1 cmd");
    rd(2, 16'h0020, "R1 rxc");
    rd(7, 16'h02F8, "R1 eobc");
    rd(3, 16'h0000, "R1 txc");
    rd(4, 16'h0000, "R1 imask");
    rd(5, 16'h0000, "R1 istat");
    rd(9, 16'h0000, "R1 camen");
    // R2 read-only
    wr(16, 16'hFFFF);
    rd(16, 16'h1A2B, "R2 cap0");
    wr(19, 16'h0000);
    rd(19, 16'h0006, "R2 rev");
    // R3 gated configuration
    wr(1, 16'hFFFF);
    rd(1, 16'hBFFF, "R3 dcfg");
    wr(6, 16'hFFFF);
    rd(6, 16'hF017, "R3 dcfg2");
    wr(0, 16'h0000);
    wr(1, 16'h1234);
    rd(1, 16'hBFFF, "R3 dcfg locked");
    wr(6, 16'h0000);
    rd(6, 16'hF017, "R3 dcfg2 locked");
    // R4 masked registers
    wr(3, 16'hFFFF);
    rd(3, 16'hF000, "R4 txc");
    wr(2, 16'hFFFF);
    rd(2, 16'hFFE0, "R4 rxc");
    wr(4, 16'hFFFF);
    rd(4, 16'h7FFF, "R4 imask");
    // R10 engine set
    @(negedge clk); stat_set = 16'h0025;
    @(negedge clk); stat_set = 16'h0000;
    rd(5, 16'h0025, "R10 set");
    // R5 W1C, bit 8 not set
    wr(5, 16'h0101);
    check("R6 no fetch", {15'd0, ring_fetch}, 16'h0000);
    rd(5, 16'h0024, "R5 w1c");
    // R9 irq
    check("R9 irq on", {15'd0, irq}, 16'h0001);
    wr(4, 16'h0001);
    check("R9 irq masked", {15'd0, irq}, 16'h0000);
    wr(4, 16'h0004);
    check("R9 irq unmasked", {15'd0, irq}, 16'h0001);
    // R6 ring fetch pulse
    wr(5, 16'h0020);
    check("R6 fetch", {15'd0, ring_fetch}, 16'h0001);
    @(negedge clk);
    check("R6 fetch one cycle", {15'd0, ring_fetch}, 16'h0000);
    rd(5, 16'h0004, "R5 exh cleared");
    wr(5, 16'h0020);
    check("R6 fetch when clear", {15'd0, ring_fetch}, 16'h0000);
    // R10 set beats same-cycle clear
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(5); wdata = 16'h0004; stat_set = 16'h0004;
    @(negedge clk);
    wr_en = 1'b0; stat_set = 16'h0000;
    rd(5, 16'h0004, "R10 priority");
    check("R9 irq held", {15'd0, irq}, 16'h0001);
    // R7 tallies
    wr(12, 16'h1234);
    rd(12, 16'hEDCB, "R7 crc tally");
    wr(14, 16'h0000);
    rd(14, 16'hFFFF, "R7 miss tally");
    // R8 watchdog restart
    wr(10, 16'h0100);
    check("R8 lo", {15'd0, wdog_restart}, 16'h0001);
    @(negedge clk);
    check("R8 pulse end", {15'd0, wdog_restart}, 16'h0000);
    wr(11, 16'h0001);
    check("R8 hi", {15'd0, wdog_restart}, 16'h0001);
    wr(9, 16'h00FF);
    check("R8 other", {15'd0, wdog_restart}, 16'h0000);
    // R11 plain storage
    wr(32, 16'hA5A5);
    wr(63, 16'h5A5A);
    rd(32, 16'hA5A5, "R11 plain");
    rd(63, 16'h5A5A, "R11 top");
    rd(9, 16'h00FF, "R11 camen");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R11 actual=%0d expected=0 pending reads", exp_q.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule